// File: doc/BRIEF.md
# Coefficient Block Column Reorder Output

This block sits after a two-dimensional transform and puts its coefficients on an auxiliary output bus. Coefficients arrive eight by eight, one per accepted beat, in row order: row 0 columns 0..7 first, then row 1, and so on. Each 64-beat block is held in storage and sent out transposed, in column order. The output starts with the DC term at row 0, column 0, then goes down column 0, then column 1, and so on. A one-cycle sync flag marks the first coefficient of every output block.

The output is not paced by a free-running engine. It follows the input. Each accepted input beat of block N+1 releases one coefficient of block N, a fixed number of clock cycles later. As a result, any idle cycles on the input, inside a block or between blocks, show up on the output with the same length after that fixed lag. When input is continuous, the first coefficient of a block leaves 81 cycles after its own first input beat. The last block sent stays held until the next block starts to arrive.

The input uses valid/ready. A beat is accepted on a rising edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, the source must keep `in_valid` and `in_coef` steady. `in_ready` is low only during reset, or when the bank that would take the next block has not yet been drained. With the default three banks this second case does not happen during normal streaming. The output has no ready signal: it is a timed bus that the receiver must take as it comes.

Top module: `coef_col_reorder`

## Requirements
- R1: Output slot k of a block, for k = 0..63, carries the input beat with index 8*(k mod 8) + (k div 8) of that block. The input beat index is 8*row + column, so the output runs in column order starting at row 0, column 0.
- R2: `out_sync` is high together with the first coefficient (the DC term) of each output block, and only then. It is never high while `out_valid` is low.
- R3: In every cycle in which `out_valid` is low, `out_coef` is zero.
- R4: An input beat accepted at rising edge n makes `out_valid` high for exactly the cycle after rising edge n+17. That cycle carries the next coefficient of the previously completed block. With back-to-back blocks, a block's first coefficient therefore follows its own first accepted beat by 81 cycles.
- R5: Idle input cycles, inside a block or between blocks, are reproduced on the output as the same idle run, 17 cycles later. They are never closed up.
- R6: The first block after reset produces no output while it is being written. Block N is released only by the beats of block N+1, so the most recent block stays held.
- R7: While `rst_n` is low (synchronous, active low), `in_ready` is low, `out_valid` and `out_sync` are low and `out_coef` is zero. A partly written block present at reset is discarded.
- R8: After reset, `in_ready` stays high throughout continuous or gapped streaming of full blocks.
- R9: Coefficients are 12-bit two's complement values. They pass through unchanged, including -2048 (0x800), 2047 (0x7FF) and -1 (0xFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input coefficient present |
| in_ready | output | 1 | Block can accept a coefficient this cycle |
| in_coef | input | 12 | Input coefficient, signed, row order |
| out_valid | output | 1 | Output coefficient present this cycle |
| out_sync | output | 1 | First coefficient (DC) of an output block |
| out_coef | output | 12 | Output coefficient, signed, column order; zero when idle |

## Verification
The transpose is driven with several input patterns:
- A linear ramp, whose values expose any swapped or mirrored index bits.
- A scrambled pattern, which separates a true transpose from a plain row-order copy.
- A block of extreme signed values (-2048, 2047, 0, -1), which catches sign or width damage.

The timing is tried with:
- Back-to-back blocks, which fix the 81-cycle block latency.
- Single idle cycles every few beats inside a block.
- A long pause between two blocks.
- Three-cycle pauses in the final block.

The gapped runs distinguish an output that follows the input with a fixed lag from one that closes gaps or drifts. A partial block cut off by reset shows whether the write position is truly cleared. The held final block confirms that output is released only by later input.

// File: rtl/coef_tp_pkg.sv
package coef_tp_pkg;

  // One stage of the pacing delay line: a slot tick and a marker for the
  // first beat of a block.
  typedef struct packed {
    logic tick;
    logic first;
  } pace_t;

endpackage

// File: rtl/coef_tp_write.sv
module coef_tp_write #(
  parameter int NCOEF     = 64,
  parameter int NUM_BANKS = 3,
  parameter int IDX_W     = 6,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NUM_BANKS-1:0] bank_full,
  output logic                 in_ready,
  output logic                 wr_en,
  output logic [BANK_W-1:0]    wr_bank,
  output logic [IDX_W-1:0]     wr_idx,
  output logic                 blk_done,
  output logic                 blk_first
);

  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NCOEF - 1);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] bank_q;
  logic [IDX_W-1:0]  idx_q;
  logic              target_busy;

  assign target_busy = (bank_q < BANK_W'(NUM_BANKS)) ? bank_full[bank_q] : 1'b1;
  assign in_ready    = rst_n && !target_busy;
  assign wr_en       = in_valid && in_ready;
  assign wr_bank     = bank_q;
  assign wr_idx      = idx_q;
  assign blk_done    = wr_en && (idx_q == LAST_IDX);
  assign blk_first   = wr_en && (idx_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      idx_q  <= '0;
    end else if (wr_en) begin
      if (idx_q == LAST_IDX) begin
        idx_q  <= '0;
        bank_q <= (bank_q == LAST_BANK) ? '0 : bank_q + 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/coef_tp_pace.sv
module coef_tp_pace
  import coef_tp_pkg::*;
#(
  parameter int LAG = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_in,
  input  logic first_in,
  output logic tap_tick,
  output logic tap_first
);

  pace_t line_q [LAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < LAG; s++) line_q[s] <= '0;
    end else begin
      line_q[0] <= '{tick: slot_in, first: first_in};
      for (int s = 1; s < LAG; s++) line_q[s] <= line_q[s-1];
    end
  end

  assign tap_tick  = line_q[LAG-1].tick;
  assign tap_first = line_q[LAG-1].first;

endmodule

// File: rtl/coef_tp_store.sv
module coef_tp_store #(
  parameter int COEF_W    = 12,
  parameter int NCOEF     = 64,
  parameter int NUM_BANKS = 3,
  parameter int IDX_W     = 6,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [BANK_W-1:0]    wr_bank,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [COEF_W-1:0]    wr_data,
  input  logic                 set_full,
  input  logic [BANK_W-1:0]    rd_bank,
  input  logic [IDX_W-1:0]     rd_addr,
  input  logic                 clr_full,
  output logic [COEF_W-1:0]    rd_data,
  output logic [NUM_BANKS-1:0] bank_full
);

  logic [COEF_W-1:0] bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [COEF_W-1:0] cells [NCOEF];
    logic              full_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == BANK_W'(b))) cells[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                                      full_q <= 1'b0;
      else if (set_full && (wr_bank == BANK_W'(b)))    full_q <= 1'b1;
      else if (clr_full && (rd_bank == BANK_W'(b)))    full_q <= 1'b0;
    end

    assign bank_rd[b]   = cells[rd_addr];
    assign bank_full[b] = full_q;
  end

  assign rd_data = (rd_bank < BANK_W'(NUM_BANKS)) ? bank_rd[rd_bank] : '0;

endmodule

// File: rtl/coef_tp_read.sv
module coef_tp_read #(
  parameter int COEF_W    = 12,
  parameter int DIM       = 8,
  parameter int NUM_BANKS = 3,
  parameter int IDX_W     = 6,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tap_tick,
  input  logic                 tap_first,
  input  logic [NUM_BANKS-1:0] bank_full,
  input  logic [COEF_W-1:0]    rd_data,
  output logic [BANK_W-1:0]    rd_bank,
  output logic [IDX_W-1:0]     rd_addr,
  output logic                 clr_full,
  output logic                 out_valid,
  output logic                 out_sync,
  output logic [COEF_W-1:0]    out_coef
);

  localparam int               HALF_W    = $clog2(DIM);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DIM * DIM - 1);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] bank_q;
  logic [IDX_W-1:0]  slot_q;
  logic              src_full;
  logic              go;

  assign src_full = (bank_q < BANK_W'(NUM_BANKS)) ? bank_full[bank_q] : 1'b0;
  // A block starts only on a block-aligned tick; once started it runs in
  // lockstep with the ticks until its last slot.
  assign go       = tap_tick && ((slot_q != '0) || (tap_first && src_full));
  assign clr_full = go && (slot_q == LAST_IDX);
  assign rd_bank  = bank_q;
  // Column-order slot k = {col, row}; the row-order cell address is {row, col}.
  assign rd_addr  = {slot_q[HALF_W-1:0], slot_q[IDX_W-1:HALF_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q    <= '0;
      slot_q    <= '0;
      out_valid <= 1'b0;
      out_sync  <= 1'b0;
      out_coef  <= '0;
    end else begin
      out_valid <= go;
      out_sync  <= go && (slot_q == '0);
      out_coef  <= go ? rd_data : '0;
      if (go) begin
        if (slot_q == LAST_IDX) begin
          slot_q <= '0;
          bank_q <= (bank_q == LAST_BANK) ? '0 : bank_q + 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/coef_col_reorder.sv
module coef_col_reorder #(
  parameter int COEF_W    = 12,
  parameter int DIM       = 8,
  parameter int NUM_BANKS = 3,
  parameter int LAG       = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [COEF_W-1:0] in_coef,
  output logic              out_valid,
  output logic              out_sync,
  output logic [COEF_W-1:0] out_coef
);

  localparam int NCOEF  = DIM * DIM;
  localparam int IDX_W  = $clog2(NCOEF);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic                 wr_en, blk_done, blk_first;
  logic [BANK_W-1:0]    wr_bank, rd_bank;
  logic [IDX_W-1:0]     wr_idx, rd_addr;
  logic [NUM_BANKS-1:0] bank_full;
  logic                 tap_tick, tap_first, clr_full;
  logic [COEF_W-1:0]    rd_data;

  coef_tp_write #(
    .NCOEF(NCOEF), .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .BANK_W(BANK_W)
  ) u_write (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bank_full(bank_full),
    .in_ready(in_ready), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .blk_done(blk_done), .blk_first(blk_first)
  );

  coef_tp_pace #(
    .LAG(LAG)
  ) u_pace (
    .clk(clk), .rst_n(rst_n), .slot_in(wr_en), .first_in(blk_first),
    .tap_tick(tap_tick), .tap_first(tap_first)
  );

  coef_tp_store #(
    .COEF_W(COEF_W), .NCOEF(NCOEF), .NUM_BANKS(NUM_BANKS),
    .IDX_W(IDX_W), .BANK_W(BANK_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_idx(wr_idx), .wr_data(in_coef), .set_full(blk_done),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .clr_full(clr_full),
    .rd_data(rd_data), .bank_full(bank_full)
  );

  coef_tp_read #(
    .COEF_W(COEF_W), .DIM(DIM), .NUM_BANKS(NUM_BANKS),
    .IDX_W(IDX_W), .BANK_W(BANK_W)
  ) u_read (
    .clk(clk), .rst_n(rst_n), .tap_tick(tap_tick), .tap_first(tap_first),
    .bank_full(bank_full), .rd_data(rd_data), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .clr_full(clr_full), .out_valid(out_valid),
    .out_sync(out_sync), .out_coef(out_coef)
  );

endmodule

// File: rtl/coef_col_reorder_chk.sv
module coef_col_reorder_chk #(
  parameter int LAG    = 17,
  parameter int COEF_W = 12,
  parameter int NCOEF  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_sync,
  input logic [COEF_W-1:0] out_coef
);

  localparam int IDX_W = $clog2(NCOEF);

  // Accepted-beat history, one bit per cycle, LAG+1 deep.
  logic [LAG:0]     accepted_hist;
  logic [IDX_W-1:0] beats_in_blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accepted_hist <= '0;
      beats_in_blk  <= '0;
    end else begin
      accepted_hist <= {accepted_hist[LAG-1:0], in_valid && in_ready};
      if (out_valid) beats_in_blk <= beats_in_blk + 1'b1;
    end
  end

  assert_sync_in_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_sync |-> out_valid);

  assert_sync_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sync == (beats_in_blk == '0)));

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_coef == '0));

  assert_paced_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> accepted_hist[LAG]);

  assert_reset_ready_R7: assert property (@(posedge clk)
    !rst_n |-> !in_ready);

endmodule

bind coef_col_reorder coef_col_reorder_chk #(
  .LAG(LAG), .COEF_W(COEF_W), .NCOEF(DIM * DIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_sync(out_sync), .out_coef(out_coef)
);

// File: tb/tb_coef_col_reorder.sv
`timescale 1ns/1ps
module tb_coef_col_reorder;
  localparam int DIM   = 8;
  localparam int NCOEF = DIM * DIM;
  localparam int LAG   = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_coef = '0;
  logic        in_ready, out_valid, out_sync;
  logic [11:0] out_coef;

  coef_col_reorder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .out_valid(out_valid), .out_sync(out_sync),
    .out_coef(out_coef)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic [11:0] val;
    logic        sync;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          sync_seen[$];
  int          first_acc[6];
  logic [11:0] prev_blk[NCOEF];
  bit          have_prev = 1'b0;
  bit          mon_on = 1'b0;
  bit          finished = 1'b0;
  int          not_ready = 0;
  int          total = 0;
  int          bad = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when an item is due, else expects idle.
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_sync === 1'b1) sync_seen.push_back(cyc);
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        check(out_valid === 1'b1, "R4", "beat present", int'(out_valid), 1);
        check(out_coef === e.val, e.tag, "coefficient",
              int'($signed(out_coef)), int'($signed(e.val)));
        check(out_sync === e.sync, "R2", "sync flag", int'(out_sync), int'(e.sync));
      end else begin
        // R3/R5/R6: no beat due, so the bus must be idle and zero
        check(out_valid === 1'b0 && out_sync === 1'b0 && out_coef === 12'h000,
              "R3/R5/R6", "idle slot valid", int'(out_valid), 0);
      end
    end
  end

  function automatic logic [11:0] pat(int blk, int i);
    case (blk)
      0: return 12'(i * 5 - 100);
      3: case (i % 4)                // R9 extremes
           0: return 12'h800;
           1: return 12'h7FF;
           2: return 12'h000;
           default: return 12'hFFF;
         endcase
      default: return 12'((i * 37 + blk * 211 + 5) % 4096);
    endcase
  endfunction

  // Driver: one block, optional idle runs every gap_every beats.
  task automatic send_block(int blk, int gap_every, int gap_len);
    logic [11:0] cur[NCOEF];
    for (int i = 0; i < NCOEF; i++) begin
      if (gap_every > 0 && i > 0 && i % gap_every == 0) begin
        in_valid = 1'b0;
        repeat (gap_len) @(negedge clk);
      end
      in_valid = 1'b1;
      in_coef  = pat(blk, i);
      cur[i]   = in_coef;
      while (in_ready !== 1'b1) begin
        not_ready++;
        @(negedge clk);
      end
      if (i == 0) first_acc[blk] = cyc + 1;
      if (have_prev) begin
        exp_t e;
        e.due  = cyc + 1 + LAG;
        e.val  = prev_blk[(i % DIM) * DIM + i / DIM];
        e.sync = (i == 0);
        e.tag  = (blk == 4) ? "R9" : "R1";
        sb.push_back(e);
      end
      @(negedge clk);
    end
    in_valid  = 1'b0;
    prev_blk  = cur;
    have_prev = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    check(in_ready === 1'b0, "R7", "ready in reset", int'(in_ready), 0);
    check(out_valid === 1'b0 && out_sync === 1'b0, "R7", "outputs in reset",
          int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R8", "ready after reset", int'(in_ready), 1);

    // R7: a partial block followed by reset must be discarded
    for (int i = 0; i < 30; i++) begin
      in_valid = 1'b1;
      in_coef  = 12'(i + 700);
      @(negedge clk);
    end
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready === 1'b0, "R7", "ready in second reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    send_block(0, 0, 0);        // ramp, R6: nothing out yet
    send_block(1, 0, 0);        // back to back, scrambled
    send_block(2, 5, 1);        // single idle cycles inside the block (R5)
    repeat (23) @(negedge clk); // long pause between blocks (R5)
    send_block(3, 0, 0);        // extreme values (R9)
    send_block(4, 0, 0);        // back to back: fixes block latency (R4)
    send_block(5, 7, 3);        // releases block 4, itself stays held (R6)
    repeat (60) @(negedge clk);

    check(sb.size() == 0, "R4", "undelivered beats", sb.size(), 0);
    check(sync_seen.size() == 5, "R6", "output blocks seen", sync_seen.size(), 5);
    if (sync_seen.size() >= 4) begin
      check(sync_seen[0] == first_acc[1] + LAG, "R6", "first block release cycle",
            sync_seen[0], first_acc[1] + LAG);
      check(sync_seen[3] - first_acc[3] == 81, "R4", "block latency",
            sync_seen[3] - first_acc[3], 81);
    end
    check(not_ready == 0, "R8", "stall cycles", not_ready, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule